// File: doc/BRIEF.md
# Dual-Rail Handshake Hold Stage

This block is a single-bit storage stage for a pipeline whose data travels as rail pairs. It watches one rail pair from the stage before it and captures the first legal codeword that follows a spacer. It keeps its own output at spacer until the stage after it asks for the value. It then presents the value, raises an acknowledge toward the stage before it, and later returns the output to spacer. Once both its output and its input are back at spacer, it drops the acknowledge and is empty again.

The stage is written as clocked logic. All outputs come from registers, and every input is sampled on the rising clock edge. A separate output flags the illegal code in which both rails are high. That code is never stored.

Top module: `dr_hold_stage`

## Requirements
- R1: The rail pair {hi, lo} encodes four states: 2'b00 is spacer, 2'b01 is data 0, 2'b10 is data 1 and 2'b11 is illegal. The output pair never shows 2'b11.
- R2: While `rst` is high at a clock edge, the outputs after that edge are `out_hi`=0, `out_lo`=0, `up_done`=0 and `code_fault`=0.
- R3: After every edge that is out of reset, `code_fault` is 1 exactly when the input pair sampled at that edge was 2'b11.
- R4: The code 2'b11 is never captured. If it arrives while the stage is empty, the output stays spacer and `up_done` stays low.
- R5: A legal word sampled while the stage is empty is captured. The output stays spacer, even if the input changes, until `dn_pull` is sampled high.
- R6: When the stage holds a word and `dn_pull` is sampled high, the output shows the captured code from the next edge onward, and `up_done` goes high at that same edge.
- R7: While `dn_pull` stays high, the presented value stays unchanged whatever the input does.
- R8: When `dn_pull` is sampled low while a value is presented, the output returns to spacer after that edge, and `up_done` stays high.
- R9: With the output at spacer and `up_done` high, the first edge at which the input is spacer clears `up_done`, and the stage becomes empty.
- R10: A new word is accepted only after a spacer has been sampled since the last word or since reset. A word left on the input keeps `up_done` high and is not captured again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_hi | input | 1 | Input rail for data 1 |
| in_lo | input | 1 | Input rail for data 0 |
| dn_pull | input | 1 | Request from the downstream stage |
| out_hi | output | 1 | Output rail for data 1 |
| out_lo | output | 1 | Output rail for data 0 |
| up_done | output | 1 | Acknowledge to the upstream stage |
| code_fault | output | 1 | Illegal input code was sampled |

## Verification
Flagging an illegal code can happen in the same cycle as the handshake steps: a 2'b11 can arrive while a word is held, presented or draining. The random phase drives 2'b11 with a fixed share of probability in every state. A directed case injects it while a word is held and then raises `dn_pull`. The check is that `code_fault` rises on the following edge while the held value, the output rails and `up_done` follow exactly the sequence they would have followed without the illegal code.

// File: rtl/dr_hold_pkg.sv
package dr_hold_pkg;
  localparam int RAIL_W = 2;
  typedef logic [RAIL_W-1:0] rail_t;

  localparam rail_t RAIL_SPACER = 2'b00;
  localparam rail_t RAIL_ZERO   = 2'b01;
  localparam rail_t RAIL_ONE    = 2'b10;
  localparam rail_t RAIL_BAD    = 2'b11;

  typedef enum logic [2:0] {
    ST_ARM   = 3'd0,  // waiting for a spacer after reset
    ST_EMPTY = 3'd1,  // ready to capture
    ST_HELD  = 3'd2,  // word stored, output still spacer
    ST_SENT  = 3'd3,  // word presented, acknowledge high
    ST_DRAIN = 3'd4   // output spacer, waiting for input spacer
  } stage_st_t;
endpackage

// File: rtl/dr_rail_classify.sv
module dr_rail_classify
  import dr_hold_pkg::*;
(
  input  rail_t code,
  output logic  is_spacer,
  output logic  is_valid,
  output logic  is_bad
);
  always_comb begin
    is_spacer = (code == RAIL_SPACER);
    is_valid  = (code == RAIL_ZERO) || (code == RAIL_ONE);
    is_bad    = (code == RAIL_BAD);
  end
endmodule

// File: rtl/dr_stage_ctrl.sv
module dr_stage_ctrl
  import dr_hold_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_spacer,
  input  logic in_valid,
  input  logic pull,
  output logic load,
  output logic drive_nxt,
  output logic done_nxt
);
  stage_st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    load = 1'b0;
    case (st_q)
      ST_ARM:   if (in_spacer) st_d = ST_EMPTY;
      ST_EMPTY: if (in_valid) begin
                  load = 1'b1;
                  st_d = ST_HELD;
                end
      ST_HELD:  if (pull) st_d = ST_SENT;
      ST_SENT:  if (!pull) st_d = ST_DRAIN;
      ST_DRAIN: if (in_spacer) st_d = ST_EMPTY;
      default:  st_d = ST_ARM;
    endcase
    drive_nxt = (st_d == ST_SENT);
    done_nxt  = (st_d == ST_SENT) || (st_d == ST_DRAIN);
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_ARM;
    else     st_q <= st_d;
  end
endmodule

// File: rtl/dr_stage_data.sv
module dr_stage_data
  import dr_hold_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  rail_t code_in,
  input  logic  in_bad,
  input  logic  load,
  input  logic  drive_nxt,
  input  logic  done_nxt,
  output rail_t code_out,
  output logic  done,
  output logic  fault
);
  rail_t hold_q;

  always_ff @(posedge clk) begin
    if (rst)       hold_q <= RAIL_SPACER;
    else if (load) hold_q <= code_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_out <= RAIL_SPACER;
      done     <= 1'b0;
      fault    <= 1'b0;
    end else begin
      code_out <= drive_nxt ? hold_q : RAIL_SPACER;
      done     <= done_nxt;
      fault    <= in_bad;
    end
  end
endmodule

// File: rtl/dr_hold_stage.sv
module dr_hold_stage
  import dr_hold_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_hi,
  input  logic in_lo,
  input  logic dn_pull,
  output logic out_hi,
  output logic out_lo,
  output logic up_done,
  output logic code_fault
);
  rail_t in_code, out_code;
  logic  in_spacer, in_valid, in_bad;
  logic  load, drive_nxt, done_nxt;

  assign in_code = {in_hi, in_lo};

  dr_rail_classify u_cls (
    .code      (in_code),
    .is_spacer (in_spacer),
    .is_valid  (in_valid),
    .is_bad    (in_bad)
  );

  dr_stage_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .in_spacer (in_spacer),
    .in_valid  (in_valid),
    .pull      (dn_pull),
    .load      (load),
    .drive_nxt (drive_nxt),
    .done_nxt  (done_nxt)
  );

  dr_stage_data u_data (
    .clk       (clk),
    .rst       (rst),
    .code_in   (in_code),
    .in_bad    (in_bad),
    .load      (load),
    .drive_nxt (drive_nxt),
    .done_nxt  (done_nxt),
    .code_out  (out_code),
    .done      (up_done),
    .fault     (code_fault)
  );

  assign out_hi = out_code[1];
  assign out_lo = out_code[0];
endmodule

// File: rtl/dr_hold_stage_chk.sv
module dr_hold_stage_chk (
  input logic clk,
  input logic rst,
  input logic in_hi,
  input logic in_lo,
  input logic dn_pull,
  input logic out_hi,
  input logic out_lo,
  input logic up_done,
  input logic code_fault
);
  logic [1:0] ic, oc;
  assign ic = {in_hi, in_lo};
  assign oc = {out_hi, out_lo};

  AST_RESET_CLEAN: assert property (@(posedge clk) rst |=> (oc == 2'b00 && !up_done && !code_fault)); // R2
  AST_NO_BAD_OUT: assert property (@(posedge clk) disable iff (rst) oc != 2'b11); // R1
  AST_FAULT_TRACK: assert property (@(posedge clk) disable iff (rst) (ic == 2'b11) |=> code_fault); // R3
  AST_FAULT_CLEAR: assert property (@(posedge clk) disable iff (rst) (ic != 2'b11) |=> !code_fault); // R3
  AST_BAD_NOT_HELD: assert property (@(posedge clk) disable iff (rst) (!up_done && oc == 2'b00 && ic == 2'b11 && !dn_pull) |=> (oc == 2'b00 && !up_done)); // R4
  AST_SHOW_WITH_DONE: assert property (@(posedge clk) disable iff (rst) (oc != 2'b00) |-> up_done); // R6
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst) (oc != 2'b00 && dn_pull) |=> $stable(oc)); // R7
  AST_RETURN_SPACER: assert property (@(posedge clk) disable iff (rst) (oc != 2'b00 && !dn_pull) |=> (oc == 2'b00 && up_done)); // R8
  AST_DONE_FALL: assert property (@(posedge clk) disable iff (rst) $fell(up_done) |-> (oc == 2'b00 && $past(ic) == 2'b00)); // R9
  AST_DRAIN_WAIT: assert property (@(posedge clk) disable iff (rst) (up_done && oc == 2'b00 && ic != 2'b00) |=> (up_done && oc == 2'b00)); // R10
endmodule

bind dr_hold_stage dr_hold_stage_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_hi      (in_hi),
  .in_lo      (in_lo),
  .dn_pull    (dn_pull),
  .out_hi     (out_hi),
  .out_lo     (out_lo),
  .up_done    (up_done),
  .code_fault (code_fault)
);

// File: tb/tb_dr_hold_stage.sv
`timescale 1ns/1ps
module tb_dr_hold_stage;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_hi = 1'b0, in_lo = 1'b0, dn_pull = 1'b0;
  logic out_hi, out_lo, up_done, code_fault;
  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dr_hold_stage dut (
    .clk(clk), .rst(rst), .in_hi(in_hi), .in_lo(in_lo), .dn_pull(dn_pull),
    .out_hi(out_hi), .out_lo(out_lo), .up_done(up_done), .code_fault(code_fault)
  );

  // Reference model written from the requirements: 0 arm, 1 empty, 2 held, 3 sent, 4 drain
  int         m_st;
  logic [1:0] m_hold, m_q;
  logic       m_done, m_fault;

  function automatic int next_st(int st, logic [1:0] c, logic p);
    case (st)
      0: return (c == 2'b00) ? 1 : 0;
      1: return (c == 2'b01 || c == 2'b10) ? 2 : 1;
      2: return p ? 3 : 2;
      3: return p ? 3 : 4;
      default: return (c == 2'b00) ? 1 : 4;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_hold = 2'b00; m_q = 2'b00; m_done = 1'b0; m_fault = 1'b0;
    end else begin
      m_fault = ({in_hi, in_lo} == 2'b11);
      if (m_st == 1 && ({in_hi, in_lo} == 2'b01 || {in_hi, in_lo} == 2'b10)) m_hold = {in_hi, in_lo};
      m_st   = next_st(m_st, {in_hi, in_lo}, dn_pull);
      m_q    = (m_st == 3) ? m_hold : 2'b00;
      m_done = (m_st == 3 || m_st == 4);
    end
  end

  task automatic chk(string tag, logic [3:0] got, logic [3:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got {q,done,fault}=%b expected %b", tag, got, exp);
    end
  endtask

  function automatic logic [3:0] pins();
    return {out_hi, out_lo, up_done, code_fault};
  endfunction

  task automatic tick(logic [1:0] c, logic p);
    in_hi = c[1]; in_lo = c[0]; dn_pull = p;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    chk("R2 reset state", pins(), 4'b0000);
    rst = 1'b0;
    tick(2'b00, 1'b0);                       // arm -> empty
    tick(2'b11, 1'b0);
    chk("R3 fault on 11 / R4 not captured", pins(), 4'b0001);
    tick(2'b00, 1'b1);
    chk("R4 still empty, pull alone does nothing", pins(), 4'b0000);
    tick(2'b10, 1'b0);                       // capture data 1
    chk("R5 held, output spacer", pins(), 4'b0000);
    tick(2'b11, 1'b0);                       // illegal while held
    chk("R3 fault while held, R5 output spacer", pins(), 4'b0001);
    tick(2'b01, 1'b1);
    chk("R6 present data 1 with done", pins(), 4'b1010);
    tick(2'b00, 1'b1);
    chk("R7 value stays while pull high", pins(), 4'b1010);
    tick(2'b01, 1'b0);
    chk("R8 back to spacer, done stays", pins(), 4'b0010);
    tick(2'b01, 1'b0);
    chk("R10 word left on input keeps done", pins(), 4'b0010);
    tick(2'b00, 1'b0);
    chk("R9 done drops on input spacer", pins(), 4'b0000);
    tick(2'b01, 1'b1);                       // capture data 0, pull already high
    chk("R5 capture cycle shows spacer", pins(), 4'b0000);
    tick(2'b01, 1'b1);
    chk("R1 data 0 is 01 on output, R6", pins(), 4'b0110);
    tick(2'b00, 1'b0);
    tick(2'b00, 1'b0);
    chk("R9 empty again", pins(), 4'b0000);
    rst = 1'b1;
    tick(2'b10, 1'b0);
    rst = 1'b0;
    tick(2'b10, 1'b0);
    tick(2'b10, 1'b1);
    chk("R10 no capture after reset without spacer", pins(), 4'b0000);
    tick(2'b00, 1'b0);
    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] c;
      int r;
      r = $urandom_range(0, 9);
      c = (r < 4) ? 2'b00 : (r < 6) ? 2'b01 : (r < 8) ? 2'b10 : 2'b11;
      tick(c, ($urandom_range(0, 2) != 0));
      chk("model R3 R5 R6 R7 R8 R9", pins(), {m_q, m_done, m_fault});
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule